// File: doc/BRIEF.md
# Partitioned SIMD Multiply-Accumulate Unit

This block is the multiply-accumulate stage of a signal-processing datapath. Each operand is 64 bits wide, formed by joining two 32-bit registers. One multiplier array serves two uses, chosen per operation:

- **Lane mode.** The array splits into four independent signed 16x16 lanes. Each lane feeds its own 40-bit accumulator, which holds a 32-bit product plus 8 guard bits.
- **Wide mode.** The same array forms one signed 32x32 product. That product goes into an 80-bit accumulator, built by chaining the storage of lanes 0 and 1.

An accepted operation either adds its product to the running sum or, when the restart control is set, starts a new sum from the product. One operation is accepted per clock. Its result shows on the accumulator outputs after the clock edge that accepts it.

Overflow is tracked per lane with sticky flags. A sum that leaves its signed range wraps; it is never saturated. Software that changes mode must restart on the first operation in the new mode, because the old contents have no meaning in the other mode.

Top module: `simd_mac_unit`

## Requirements
- R1: When reset is asserted, all accumulator bits and all overflow flags read zero.
- R2: Lane mode (`wide_mode`=0) with `restart`=1 loads each lane k with the signed product of operand bits [16k+15:16k], sign-extended to 40 bits. Lane k is shown on `acc_flat[40k+39:40k]`.
- R3: Lane mode with `restart`=0 adds each lane product to that lane's 40-bit sum. No carry or borrow ever passes between lanes.
- R4: Wide mode (`wide_mode`=1) multiplies the signed low halves `op_a[31:0]` and `op_b[31:0]`; bits [63:32] of both operands are ignored. A restart loads the sign-extended 64-bit product into `acc_flat[79:0]`, zeroes `acc_flat[159:80]` and clears all four flags.
- R5: Wide mode with `restart`=0 adds the sign-extended 64-bit product to the 80-bit sum in `acc_flat[79:0]`. `acc_flat[159:80]` and flags [3:1] are left unchanged.
- R6: While `op_valid`=0, the accumulators and flags hold their values, whatever the other inputs do.
- R7: A lane sum that leaves the signed 40-bit range wraps modulo 2^40 and sets that lane's flag. In wide mode, an 80-bit overflow sets flag 0. Flags stay set until a restart or reset.
- R8: Any accepted operation with `restart`=1 clears every flag that the new product does not itself set.
- R9: One operation is accepted on every clock edge with `op_valid`=1, with no stall. Its result is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accept one multiply-accumulate operation on this edge |
| wide_mode | input | 1 | 1: one 32x32 operation; 0: four 16x16 lanes |
| restart | input | 1 | 1: new sum starts from the product; 0: product is added to the sum |
| op_a | input | 64 | First operand: two joined 32-bit registers |
| op_b | input | 64 | Second operand: two joined 32-bit registers |
| acc_flat | output | 160 | Four 40-bit lane sums; in wide mode bits [79:0] hold the 80-bit sum |
| ovf_flags | output | 4 | Sticky overflow flag per lane; bit 0 holds the wide-mode flag |

## Verification
The bound checker verifies the following on every clock:
- idle operations hold all state;
- flags stay sticky between restarts;
- every internal overflow event reaches its flag;
- a restart clears the flags;
- lane-0 and wide restarts load the expected products;
- in wide mode the upper segments neither carry nor keep data after a restart.

Some behaviour only the bench scenarios can show:
- correct sums across long accumulation chains;
- independence of all four lanes under mixed-sign data;
- the exact wrap value and flag timing after 512 maximum products;
- that the upper operand halves really have no effect in wide mode.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int LANES      = 4;
  localparam int LANE_W_DEF = 16;
  localparam int GUARD_DEF  = 8;

  // Signedness of the two multiplier inputs: first letter for A, second for B
  typedef enum logic [1:0] {
    MUL_SS = 2'd0,
    MUL_SU = 2'd1,
    MUL_US = 2'd2,
    MUL_UU = 2'd3
  } mul_sign_e;
endpackage

// File: rtl/mac_mul_array.sv
module mac_mul_array
  import mac_pkg::*;
#(
  parameter  int LANE_W = LANE_W_DEF,
  localparam int OPW    = LANES * LANE_W,
  localparam int PW     = 2 * LANE_W,
  localparam int RW     = 2 * LANE_W + 2
) (
  input  logic                      wide_mode,
  input  logic [OPW-1:0]            op_a,
  input  logic [OPW-1:0]            op_b,
  output logic [LANES-1:0][PW-1:0]  lane_prod,
  output logic [OPW-1:0]            wide_prod
);

  // Which operand field feeds multiplier m in wide mode (half-words 0/1)
  function automatic int wide_src_a(input int m);
    return (m == 1 || m == 2) ? 1 : 0;
  endfunction

  function automatic int wide_src_b(input int m);
    return (m == 1 || m == 3) ? 1 : 0;
  endfunction

  function automatic mul_sign_e wide_sign(input int m);
    case (m)
      0:       return MUL_UU;
      1:       return MUL_SS;
      2:       return MUL_SU;
      default: return MUL_US;
    endcase
  endfunction

  function automatic logic [LANE_W:0] widen(input logic [LANE_W-1:0] f, input logic sgn);
    return {sgn & f[LANE_W-1], f};
  endfunction

  // Recombine four partial products into the 2*PW-bit signed product
  function automatic logic [OPW-1:0] merge(input logic signed [RW-1:0] r0,
                                           input logic signed [RW-1:0] r1,
                                           input logic signed [RW-1:0] r2,
                                           input logic signed [RW-1:0] r3);
    logic signed [OPW-1:0] e0, e1, e2, e3;
    e0 = r0;
    e1 = r1;
    e2 = r2;
    e3 = r3;
    return e0 + (e2 <<< LANE_W) + (e3 <<< LANE_W) + (e1 <<< (2 * LANE_W));
  endfunction

  logic signed [RW-1:0] raw_all [LANES];

  for (genvar m = 0; m < LANES; m++) begin : g_mul
    mul_sign_e          md;
    logic [LANE_W-1:0]  fa, fb;
    logic [LANE_W:0]    xa, xb;

    always_comb begin
      md = wide_mode ? wide_sign(m) : MUL_SS;
      fa = wide_mode ? op_a[wide_src_a(m)*LANE_W +: LANE_W] : op_a[m*LANE_W +: LANE_W];
      fb = wide_mode ? op_b[wide_src_b(m)*LANE_W +: LANE_W] : op_b[m*LANE_W +: LANE_W];
      xa = widen(fa, (md == MUL_SS) || (md == MUL_SU));
      xb = widen(fb, (md == MUL_SS) || (md == MUL_US));
    end

    assign raw_all[m]   = $signed(xa) * $signed(xb);
    assign lane_prod[m] = raw_all[m][PW-1:0];
  end

  assign wide_prod = merge(raw_all[0], raw_all[1], raw_all[2], raw_all[3]);

endmodule

// File: rtl/mac_acc_seg.sv
module mac_acc_seg #(
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             restart,
  input  logic [ACC_W-1:0] addend,
  input  logic             cin,
  output logic [ACC_W-1:0] acc_q,
  output logic             cout,
  output logic             ovf_raw
);

  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] sum;

  always_comb begin
    base          = restart ? '0 : acc_q;
    {cout, sum}   = {1'b0, base} + {1'b0, addend} + {{ACC_W{1'b0}}, cin};
    ovf_raw       = (base[ACC_W-1] == addend[ACC_W-1]) && (sum[ACC_W-1] != base[ACC_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (load_en) begin
      acc_q <= sum;
    end
  end

endmodule

// File: rtl/mac_addend_route.sv
module mac_addend_route
  import mac_pkg::*;
#(
  parameter  int LANE_W = LANE_W_DEF,
  parameter  int GUARD  = GUARD_DEF,
  localparam int OPW    = LANES * LANE_W,
  localparam int PW     = 2 * LANE_W,
  localparam int ACC_W  = PW + GUARD
) (
  input  logic                        wide_mode,
  input  logic [LANES-1:0][PW-1:0]    lane_prod,
  input  logic [OPW-1:0]              wide_prod,
  input  logic                        carry_lo,
  input  logic [LANES-1:0]            seg_ovf_raw,
  output logic [LANES-1:0][ACC_W-1:0] addend,
  output logic [LANES-1:0]            seg_cin,
  output logic [LANES-1:0]            ovf_map
);

  function automatic logic [ACC_W-1:0] lane_ext(input logic [PW-1:0] p);
    logic signed [ACC_W-1:0] e;
    e = $signed(p);
    return e;
  endfunction

  logic signed [2*ACC_W-1:0] wide_ext;
  assign wide_ext = $signed(wide_prod);

  for (genvar k = 0; k < LANES; k++) begin : g_route
    if (k < 2) begin : g_pair
      assign addend[k] = wide_mode ? wide_ext[k*ACC_W +: ACC_W] : lane_ext(lane_prod[k]);
    end else begin : g_upper
      assign addend[k] = wide_mode ? '0 : lane_ext(lane_prod[k]);
    end
    if (k == 1) begin : g_chain
      assign seg_cin[k] = wide_mode & carry_lo;
    end else begin : g_nochain
      assign seg_cin[k] = 1'b0;
    end
  end

  // In wide mode the 80-bit overflow is detected at the top of segment 1
  assign ovf_map = wide_mode ? {{(LANES-1){1'b0}}, seg_ovf_raw[1]} : seg_ovf_raw;

endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
  import mac_pkg::*;
#(
  parameter  int LANE_W = LANE_W_DEF,
  parameter  int GUARD  = GUARD_DEF,
  localparam int OPW    = LANES * LANE_W,
  localparam int PW     = 2 * LANE_W,
  localparam int ACC_W  = PW + GUARD
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic                   wide_mode,
  input  logic                   restart,
  input  logic [OPW-1:0]         op_a,
  input  logic [OPW-1:0]         op_b,
  output logic [LANES*ACC_W-1:0] acc_flat,
  output logic [LANES-1:0]       ovf_flags
);

  logic [LANES-1:0][PW-1:0]    lane_prod;
  logic [OPW-1:0]              wide_prod;
  logic [LANES-1:0][ACC_W-1:0] addend;
  logic [LANES-1:0]            seg_cin;
  logic [LANES-1:0]            seg_cout;
  logic [LANES-1:0]            seg_ovf_raw;
  logic [LANES-1:0]            ovf_map;
  logic [LANES-1:0]            ovf_event;

  mac_mul_array #(.LANE_W(LANE_W)) mul_i (
    .wide_mode (wide_mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .lane_prod (lane_prod),
    .wide_prod (wide_prod)
  );

  mac_addend_route #(.LANE_W(LANE_W), .GUARD(GUARD)) route_i (
    .wide_mode   (wide_mode),
    .lane_prod   (lane_prod),
    .wide_prod   (wide_prod),
    .carry_lo    (seg_cout[0]),
    .seg_ovf_raw (seg_ovf_raw),
    .addend      (addend),
    .seg_cin     (seg_cin),
    .ovf_map     (ovf_map)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_seg
    mac_acc_seg #(.ACC_W(ACC_W)) seg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (op_valid),
      .restart (restart),
      .addend  (addend[k]),
      .cin     (seg_cin[k]),
      .acc_q   (acc_flat[k*ACC_W +: ACC_W]),
      .cout    (seg_cout[k]),
      .ovf_raw (seg_ovf_raw[k])
    );
  end

  // Overflow events of accepted operations, brought out for the checker
  assign ovf_event = {LANES{op_valid}} & ovf_map;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flags <= '0;
    end else if (op_valid) begin
      ovf_flags <= (restart ? '0 : ovf_flags) | ovf_event;
    end
  end

endmodule

// File: rtl/simd_mac_checker.sv
module simd_mac_checker
  import mac_pkg::*;
#(
  parameter  int LANE_W = LANE_W_DEF,
  parameter  int GUARD  = GUARD_DEF,
  localparam int PW     = 2 * LANE_W,
  localparam int ACC_W  = PW + GUARD
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   op_valid,
  input logic                   wide_mode,
  input logic                   restart,
  input logic [PW-1:0]          a_lo,
  input logic [PW-1:0]          b_lo,
  input logic [LANES*ACC_W-1:0] acc_flat,
  input logic [LANES-1:0]       ovf_flags,
  input logic [LANES-1:0]       ovf_event,
  input logic [LANES-1:0]       seg_cout
);

  logic signed [PW-1:0]        p0;
  logic signed [ACC_W-1:0]     p0x;
  logic signed [2*PW-1:0]      wp;
  logic signed [2*ACC_W-1:0]   wpx;

  assign p0  = $signed(a_lo[LANE_W-1:0]) * $signed(b_lo[LANE_W-1:0]);
  assign p0x = p0;
  assign wp  = $signed(a_lo) * $signed(b_lo);
  assign wpx = wp;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (acc_flat == '0 && ovf_flags == '0))
    else $error("R1 reset did not clear state");

  assert_lane0_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && restart && !wide_mode) |=> acc_flat[ACC_W-1:0] == $past(p0x))
    else $error("R2 lane 0 restart value wrong");

  assert_wide_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && restart && wide_mode) |=> acc_flat[2*ACC_W-1:0] == $past(wpx))
    else $error("R4 wide restart value wrong");

  assert_wide_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && restart && wide_mode) |=> acc_flat[LANES*ACC_W-1:2*ACC_W] == '0)
    else $error("R4 upper segments not zeroed");

  assert_wide_upper_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wide_mode) |-> (seg_cout[3:2] == 2'b00 && $countones(seg_cout[3:1]) <= 1))
    else $error("R5 upper segment produced a carry in wide mode");

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_flat) && $stable(ovf_flags)))
    else $error("R6 state changed while idle");

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !restart) |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)))
    else $error("R7 flag dropped without restart");

  assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && restart) |=> ovf_flags == '0)
    else $error("R8 restart left a flag set");

  for (genvar k = 0; k < LANES; k++) begin : g_evt
    assert_event_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_event[k] |=> ovf_flags[k])
      else $error("R7 overflow event lost on lane %0d", k);
  end

endmodule

bind simd_mac_unit simd_mac_checker #(.LANE_W(LANE_W), .GUARD(GUARD)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .wide_mode (wide_mode),
  .restart   (restart),
  .a_lo      (op_a[2*LANE_W-1:0]),
  .b_lo      (op_b[2*LANE_W-1:0]),
  .acc_flat  (acc_flat),
  .ovf_flags (ovf_flags),
  .ovf_event (ovf_event),
  .seg_cout  (seg_cout)
);

// File: tb/simd_mac_unit_tb_top.sv
module simd_mac_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         wide_mode = 1'b0;
  logic         restart = 1'b0;
  logic [63:0]  op_a = '0;
  logic [63:0]  op_b = '0;
  logic [159:0] acc_flat;
  logic [3:0]   ovf_flags;

  logic [159:0] exp_acc;
  logic [3:0]   exp_ovf;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #10 clk = ~clk;

  simd_mac_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .wide_mode (wide_mode),
    .restart   (restart),
    .op_a      (op_a),
    .op_b      (op_b),
    .acc_flat  (acc_flat),
    .ovf_flags (ovf_flags)
  );

  typedef struct packed {
    logic        wide;
    logic        rs;
    logic [63:0] a;
    logic [63:0] b;
  } stim_t;

  localparam int NSTIM = 10;
  localparam stim_t STIM [NSTIM] = '{
    '{1'b0, 1'b1, 64'h7FFF_8000_0003_FFFF, 64'h7FFF_8000_FFFD_0002},
    '{1'b0, 1'b0, 64'h0001_0002_0003_0004, 64'h8000_7FFF_0100_FFFF},
    '{1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    '{1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_F0F0_1111_EEEE},
    '{1'b1, 1'b1, 64'hDEAD_BEEF_8000_0000, 64'h1234_5678_8000_0000},
    '{1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_7FFF_FFFF},
    '{1'b1, 1'b0, 64'h0000_0000_1234_5678, 64'h0000_0000_9ABC_DEF0},
    '{1'b1, 1'b0, 64'h5555_0000_8000_0000, 64'h0000_AAAA_7FFF_FFFF},
    '{1'b0, 1'b1, 64'h0000_8000_7FFF_0001, 64'h0000_8000_8000_FFFF},
    '{1'b0, 1'b0, 64'hC001_3FFE_0101_8001, 64'h7FF0_C000_FF00_8001}
  };

  // Reference model: lanes with 64-bit integers, wide path with 128-bit math
  task automatic model_step(input logic w, input logic rs, input logic [63:0] a, input logic [63:0] b);
    if (!w) begin
      for (int k = 0; k < 4; k++) begin
        longint p, base, s;
        logic   o;
        p    = longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
        base = rs ? 64'sd0 : longint'($signed(exp_acc[40*k +: 40]));
        s    = base + p;
        o    = (s > ((64'sd1 <<< 39) - 1)) || (s < -(64'sd1 <<< 39));
        exp_acc[40*k +: 40] = s[39:0];
        exp_ovf[k] = (rs ? 1'b0 : exp_ovf[k]) | o;
      end
    end else begin
      logic signed [127:0] p, base, s, lim;
      logic o;
      p    = $signed(a[31:0]) * $signed(b[31:0]);
      base = rs ? 128'sd0 : 128'($signed(exp_acc[79:0]));
      s    = base + p;
      lim  = 128'sd1 <<< 79;
      o    = (s >= lim) || (s < -lim);
      exp_acc[79:0] = s[79:0];
      if (rs) begin
        exp_acc[159:80] = '0;
        exp_ovf = {3'b000, o};
      end else begin
        exp_ovf[0] = exp_ovf[0] | o;
      end
    end
  endtask

  task automatic do_op(input logic w, input logic rs, input logic [63:0] a, input logic [63:0] b);
    op_valid  = 1'b1;
    wide_mode = w;
    restart   = rs;
    op_a      = a;
    op_b      = b;
    model_step(w, rs, a, b);
    @(negedge clk);
  endtask

  task automatic go_idle();
    op_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    n_chk++;
    if (acc_flat !== exp_acc || ovf_flags !== exp_ovf) begin
      n_bad++;
      $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b", tag, acc_flat, ovf_flags, exp_acc, exp_ovf);
    end
  endtask

  task automatic check_val(input string tag, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog: actual=run still active expected=finished");
    report();
  end

  initial begin
    logic [159:0] snap;
    exp_acc = '0;
    exp_ovf = '0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state after reset
    check_state("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk, one operation per cycle back to back
    for (int i = 0; i < NSTIM; i++) begin
      do_op(STIM[i].wide, STIM[i].rs, STIM[i].a, STIM[i].b);
      if (!STIM[i].wide && STIM[i].rs)       check_state("R2 lane restart");
      else if (!STIM[i].wide)                check_state("R3 lane accumulate");
      else if (STIM[i].rs)                   check_state("R4 wide restart");
      else                                   check_state("R5 wide accumulate");
    end

    // R6: idle cycles with disturbing inputs
    snap = acc_flat;
    op_valid  = 1'b0;
    wide_mode = 1'b1;
    restart   = 1'b1;
    op_a      = 64'hFFFF_FFFF_FFFF_FFFF;
    op_b      = 64'h8000_8000_8000_8000;
    @(negedge clk);
    @(negedge clk);
    check_val("R6 idle hold acc", acc_flat, snap);
    check_state("R6 idle hold flags");

    // R4: upper operand halves have no effect in wide mode
    do_op(1'b1, 1'b1, 64'hAAAA_AAAA_0000_1234, 64'h5555_5555_FFFF_0003);
    snap = acc_flat;
    check_state("R4 wide low halves");
    do_op(1'b1, 1'b1, 64'h1357_9BDF_0000_1234, 64'hFEDC_BA98_FFFF_0003);
    check_val("R4 upper halves ignored", acc_flat, snap);

    // R7/R9/R3: drive lane 0 to overflow with maximal products, one per cycle
    do_op(1'b0, 1'b1, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000);
    for (int n = 0; n < 510; n++) begin
      do_op(1'b0, 1'b0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000);
    end
    check_val("R9 511 ops in 511 cycles", acc_flat, {120'h0, 40'h7F_C000_0000});
    check_val("R7 no flag before limit", {156'h0, ovf_flags}, 160'h0);
    do_op(1'b0, 1'b0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000);
    check_val("R7 lane 0 wrap value", acc_flat, {120'h0, 40'h80_0000_0000});
    check_val("R7 lane 0 flag set", {156'h0, ovf_flags}, 160'h1);
    check_val("R3 no carry into lane 1", {120'h0, acc_flat[79:40]}, 160'h0);
    do_op(1'b0, 1'b0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000);
    check_val("R7 flag sticky", {156'h0, ovf_flags}, 160'h1);
    check_val("R7 wrapped sum continues", acc_flat, {120'h0, 40'h80_4000_0000});
    check_state("R7 model after wrap");

    // R8: restart clears the flag
    do_op(1'b0, 1'b1, 64'h0004_0003_0002_0001, 64'h0001_0001_0001_0001);
    check_val("R8 restart clears flags", {156'h0, ovf_flags}, 160'h0);
    check_state("R8 restart value");

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    exp_acc = '0;
    exp_ovf = '0;
    go_idle();
    check_state("R1 mid-run reset");
    rst_n = 1'b1;
    go_idle();
    check_state("R1 after reset release");

    report();
  end

endmodule